// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the integer execution stage of a small load/store processor core. Each cycle it may accept one operation: two 32-bit register operands, a 5-bit constant shift amount and a 5-bit operation selector. One clock later it returns the 32-bit result, a register write enable and a one-cycle overflow trap strobe. The operation set covers signed and wrapping addition and subtraction, signed and unsigned set-on-less-than, the four bitwise operations AND, OR, NOR and XOR, and three shift kinds plus two rotate kinds. The shifts and rotates take their amount either from the constant field or from the low bits of the first operand.

The core's exception logic uses the trap strobe. When the strobe rises, the write enable stays low in the same cycle, so the destination register keeps its old value. The wrapping arithmetic forms and every other operation never raise the trap.

Top module: `int_exec_unit`

## Requirements
- R1: Signed add (selector 0) raises `ovf_trap` exactly when both operands have the same sign and the sum's sign differs from it. Signed subtract (selector 2, `src_a - src_b`) raises it exactly when the operand signs differ and the difference's sign differs from the sign of `src_a`. `result` always carries the wrapped 32-bit value.
- R2: Wrapping add (selector 1) and wrapping subtract (selector 3) return the modulo-2^32 value and never raise `ovf_trap`.
- R3: In a cycle with `ovf_trap` high, `wr_en` is low. For every other valid, defined operation, `wr_en` is high.
- R4: Signed compare (selector 4) and unsigned compare (selector 5) return 32'h0000_0001 when `src_a < src_b` and 32'h0000_0000 otherwise. With `src_a`=32'hFFFF_FFFF and `src_b`=32'h0000_0001, the signed form gives 1 and the unsigned form gives 0.
- R5: Selector 6 gives bitwise AND, 7 gives OR, 8 gives NOR and 9 gives XOR of `src_a` and `src_b`.
- R6: Selector 10 shifts `src_b` left by `shamt`, and selector 11 shifts it right by `shamt`. Both fill the vacated bits with zeros and drop the bits shifted out.
- R7: Selector 12 shifts `src_b` right by `shamt` and copies bit 31 into every vacated high bit.
- R8: Selectors 13 (left logical), 14 (right logical), 15 (right arithmetic), 18 (rotate left) and 19 (rotate right) take their amount from `src_a[4:0]`. Bits 31:5 of `src_a` and the `shamt` input have no effect on these operations.
- R9: Selector 16 rotates `src_b` left by `shamt`, and selector 17 rotates it right by `shamt`. Bits leaving one end re-enter at the other end, and an amount of 0 returns `src_b` unchanged.
- R10: Results appear one clock after `in_valid`, together with `out_valid`. While reset is held, and while no operation is valid, `out_valid`, `wr_en`, `ovf_trap` and `result` are all 0.
- R11: Selectors 20 through 31 are undefined. For these, `out_valid` follows `in_valid`, but `result` is 0 and both `wr_en` and `ovf_trap` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 5 | Operation selector |
| src_a | input | 32 | First operand; its low 5 bits give the variable shift amount |
| src_b | input | 32 | Second operand; the value that shifts and rotates act on |
| shamt | input | 5 | Constant shift or rotate amount |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed arithmetic overflow strobe |
| wr_en | output | 1 | Destination register write enable |

## Verification
The bench drives operands that sit exactly on the overflow boundary. It uses 32'h7FFF_FFFF plus 1, 32'h8000_0000 minus 1, and mixed-sign pairs that cannot overflow. A design that takes the signed check from carry-out, or that applies the subtract rule to addition, would trap on the wrong pairs. The same boundary pairs also go through the wrapping forms, where any trap at all, or a write enable that stays high during a trap, shows up. The compare pair 32'hFFFF_FFFF against 1 separates a signed compare from an unsigned one. Shifts of negative values by 0 and by 31, and variable-amount operations with garbage in `src_a[31:5]`, expose a wrong fill bit, a rotate that drops bits, or an amount taken from too many bits or from the wrong field.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned SHW   = $clog2(XLEN);
    localparam int unsigned OPW   = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_SLT  = 5'd4,
        OP_SLTU = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_NOR  = 5'd8,
        OP_XOR  = 5'd9,
        OP_SLL  = 5'd10,
        OP_SRL  = 5'd11,
        OP_SRA  = 5'd12,
        OP_SLLV = 5'd13,
        OP_SRLV = 5'd14,
        OP_SRAV = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_ROLV = 5'd18,
        OP_RORV = 5'd19
    } op_e;

    typedef enum logic [2:0] {
        SH_LL  = 3'd0,
        SH_RL  = 3'd1,
        SH_RA  = 3'd2,
        SH_ROL = 3'd3,
        SH_ROR = 3'd4
    } shift_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOR = 2'd2,
        LG_XOR = 2'd3
    } logic_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] res;
        logic            ovf;
        logic            we;
        logic [OPW-1:0]  op;
    } stage_t;

endpackage

// File: rtl/int_exec_addsub.sv
module int_exec_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf_s,
    output logic         lt_s,
    output logic         lt_u
);
    localparam int unsigned MSB = W - 1;

    logic [W:0]   ext;
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = b ^ {W{sub}};
        ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = ext[W-1:0];
        // Sign-based overflow: operand signs versus result sign
        if (sub) begin
            ovf_s = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
        end else begin
            ovf_s = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        end
        // Valid only when sub is set: borrow means a < b unsigned
        lt_u = ~ext[W];
        lt_s = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
    end
endmodule

// File: rtl/int_exec_logic.sv
module int_exec_logic
    import int_exec_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_e       fn,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (fn)
                LG_AND:  y[i] = a[i] & b[i];
                LG_OR:   y[i] = a[i] | b[i];
                LG_NOR:  y[i] = ~(a[i] | b[i]);
                default: y[i] = a[i] ^ b[i];
            endcase
        end
    end
endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift
    import int_exec_pkg::*;
#(
    parameter int unsigned W = 32,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    input  shift_e        kind,
    output logic [W-1:0]  y
);
    localparam int unsigned MSB = W - 1;

    logic [2*W-1:0] dbl;
    logic [2*W-1:0] rol_w;
    logic [2*W-1:0] ror_w;

    always_comb begin
        dbl   = {data, data};
        rol_w = dbl << amt;
        ror_w = dbl >> amt;
        unique case (kind)
            SH_LL:   y = data << amt;
            SH_RL:   y = data >> amt;
            SH_RA:   y = W'($signed(data) >>> amt);
            SH_ROL:  y = rol_w[2*W-1:W];
            default: y = ror_w[W-1:0];
        endcase
    end

    always_comb begin
        // R7: arithmetic right keeps the sign bit in place
        if (kind == SH_RA) AST_SRA_SIGN_KEPT: assert (y[MSB] == data[MSB]); // R7
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int unsigned W = XLEN,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [AW-1:0] shamt,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          ovf_trap,
    output logic          wr_en
);
    typedef struct packed {
        logic          valid;
        logic [W-1:0]  res;
        logic          ovf;
        logic          we;
        logic [OPW-1:0] op;
    } st_t;

    st_t st_d, st_q;

    logic          as_sub;
    logic [W-1:0]  as_sum;
    logic          as_ovf, as_lts, as_ltu;
    logic_e        lg_fn;
    logic [W-1:0]  lg_y;
    shift_e        sh_kind;
    logic [AW-1:0] sh_amt;
    logic [W-1:0]  sh_y;

    int_exec_addsub #(.W(W)) u_addsub (
        .a(src_a), .b(src_b), .sub(as_sub),
        .sum(as_sum), .ovf_s(as_ovf), .lt_s(as_lts), .lt_u(as_ltu)
    );

    int_exec_logic #(.W(W)) u_logic (
        .a(src_a), .b(src_b), .fn(lg_fn), .y(lg_y)
    );

    int_exec_shift #(.W(W)) u_shift (
        .data(src_b), .amt(sh_amt), .kind(sh_kind), .y(sh_y)
    );

    always_comb begin
        as_sub  = 1'b1;
        lg_fn   = LG_AND;
        sh_kind = SH_LL;
        sh_amt  = shamt;
        st_d    = '0;
        st_d.valid = in_valid;
        st_d.op    = op_sel;
        if (in_valid) begin
            st_d.we = 1'b1;
            unique case (op_sel)
                OP_ADD:  begin as_sub = 1'b0; st_d.res = as_sum; st_d.ovf = as_ovf; end
                OP_ADDU: begin as_sub = 1'b0; st_d.res = as_sum; end
                OP_SUB:  begin st_d.res = as_sum; st_d.ovf = as_ovf; end
                OP_SUBU: st_d.res = as_sum;
                OP_SLT:  st_d.res = {{(W-1){1'b0}}, as_lts};
                OP_SLTU: st_d.res = {{(W-1){1'b0}}, as_ltu};
                OP_AND:  begin lg_fn = LG_AND; st_d.res = lg_y; end
                OP_OR:   begin lg_fn = LG_OR;  st_d.res = lg_y; end
                OP_NOR:  begin lg_fn = LG_NOR; st_d.res = lg_y; end
                OP_XOR:  begin lg_fn = LG_XOR; st_d.res = lg_y; end
                OP_SLL:  begin sh_kind = SH_LL;  st_d.res = sh_y; end
                OP_SRL:  begin sh_kind = SH_RL;  st_d.res = sh_y; end
                OP_SRA:  begin sh_kind = SH_RA;  st_d.res = sh_y; end
                OP_SLLV: begin sh_kind = SH_LL;  sh_amt = src_a[AW-1:0]; st_d.res = sh_y; end
                OP_SRLV: begin sh_kind = SH_RL;  sh_amt = src_a[AW-1:0]; st_d.res = sh_y; end
                OP_SRAV: begin sh_kind = SH_RA;  sh_amt = src_a[AW-1:0]; st_d.res = sh_y; end
                OP_ROL:  begin sh_kind = SH_ROL; st_d.res = sh_y; end
                OP_ROR:  begin sh_kind = SH_ROR; st_d.res = sh_y; end
                OP_ROLV: begin sh_kind = SH_ROL; sh_amt = src_a[AW-1:0]; st_d.res = sh_y; end
                OP_RORV: begin sh_kind = SH_ROR; sh_amt = src_a[AW-1:0]; st_d.res = sh_y; end
                default: st_d.we = 1'b0;
            endcase
            if (st_d.ovf) st_d.we = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign ovf_trap  = st_q.ovf;
    assign wr_en     = st_q.we;

    AST_NO_WRITE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !wr_en); // R3
    AST_WRAP_NEVER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (st_q.op == OP_ADDU || st_q.op == OP_SUBU)) |-> !ovf_trap); // R2
    AST_TRAP_ONLY_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (out_valid && (st_q.op == OP_ADD || st_q.op == OP_SUB))); // R1
    AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (st_q.op == OP_SLT || st_q.op == OP_SLTU)) |-> (result[W-1:1] == '0)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !ovf_trap && result == '0)); // R10
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.op > OPW'(19)) |-> (!wr_en && !ovf_trap && result == '0)); // R11
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
    typedef struct {
        logic [31:0] res;
        logic        ovf;
        logic        we;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  shamt = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_trap;
    logic        wr_en;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .shamt(shamt),
        .out_valid(out_valid), .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en)
    );

    function automatic exp_t model(input logic [4:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [4:0] sh,
                                   input string req);
        exp_t e;
        logic [32:0] wide;
        logic [4:0]  amt;
        logic [63:0] dd;
        e.res = '0; e.ovf = 1'b0; e.we = 1'b1; e.req = req;
        amt = (op >= 5'd13 && op <= 5'd15) || op >= 5'd18 ? a[4:0] : sh;
        dd = {b, b};
        case (op)
            5'd0, 5'd1: begin
                wide = {a[31], a} + {b[31], b};
                e.res = wide[31:0];
                if (op == 5'd0) e.ovf = wide[32] != wide[31];
            end
            5'd2, 5'd3: begin
                wide = {a[31], a} - {b[31], b};
                e.res = wide[31:0];
                if (op == 5'd2) e.ovf = wide[32] != wide[31];
            end
            5'd4: e.res = {31'd0, $signed(a) < $signed(b)};
            5'd5: e.res = {31'd0, a < b};
            5'd6: e.res = a & b;
            5'd7: e.res = a | b;
            5'd8: e.res = ~(a | b);
            5'd9: e.res = a ^ b;
            5'd10, 5'd13: e.res = b << amt;
            5'd11, 5'd14: e.res = b >> amt;
            5'd12, 5'd15: begin
                e.res = b >> amt;
                for (int i = 0; i < 32; i++) if (i >= 32 - int'(amt)) e.res[i] = b[31];
            end
            5'd16, 5'd18: e.res = (amt == 0) ? b : (b << amt) | (b >> (6'd32 - amt));
            5'd17, 5'd19: e.res = (amt == 0) ? b : (b >> amt) | (b << (6'd32 - amt));
            default: e.we = 1'b0;
        endcase
        if (e.ovf) e.we = 1'b0;
        if (op > 5'd19) e.res = '0;
        return e;
    endfunction

    task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input string req);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; shamt = sh;
        sb_q.push_back(model(op, a, b, sh, req));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; op_sel = '0; src_a = '0; src_b = '0; shamt = '0;
    endtask

    // Monitor: outputs change after a posedge; sample at the following negedge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL R10: unexpected out_valid, result=%h expected no output", result);
            end else begin
                e = sb_q.pop_front();
                if (result !== e.res || ovf_trap !== e.ovf || wr_en !== e.we) begin
                    n_errors++;
                    $display("FAIL %s: res=%h ovf=%b we=%b expected res=%h ovf=%b we=%b",
                             e.req, result, ovf_trap, wr_en, e.res, e.ovf, e.we);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                n_checks++;
                if (out_valid !== 1'b0 || result !== '0 || ovf_trap !== 1'b0 || wr_en !== 1'b0) begin
                    n_errors++;
                    $display("FAIL R10: reset outputs v=%b res=%h ovf=%b we=%b expected all 0",
                             out_valid, result, ovf_trap, wr_en);
                end
                rst_n = 1'b1;
                // R1 signed add/sub boundaries
                drive(5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R1 add pos ovf");
                drive(5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, "R1 add neg ovf");
                drive(5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R1 add mixed no ovf");
                drive(5'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, "R1 sub ovf");
                drive(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R1 sub ovf pos");
                drive(5'd2, 32'hFFFF_FFFF, 32'h8000_0000, 5'd0, "R1 sub same sign");
                // R2 wrapping forms with the same operands; R3 write enable
                drive(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R2 addu wrap");
                drive(5'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, "R2 subu wrap");
                drive(5'd1, 32'hFFFF_FFFF, 32'h0000_0002, 5'd0, "R3 addu write");
                // R4 compares
                drive(5'd4, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R4 slt signed");
                drive(5'd5, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R4 sltu unsigned");
                drive(5'd4, 32'h0000_0005, 32'h0000_0005, 5'd0, "R4 slt equal");
                // R5 logic
                drive(5'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R5 and");
                drive(5'd7, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R5 or");
                drive(5'd8, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R5 nor");
                drive(5'd9, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R5 xor");
                // R6 / R7 constant shifts
                drive(5'd10, 32'h0, 32'h8000_00AD, 5'd4, "R6 sll");
                drive(5'd11, 32'h0, 32'h8000_00AD, 5'd31, "R6 srl 31");
                drive(5'd12, 32'h0, 32'hA800_0000, 5'd27, "R7 sra neg");
                drive(5'd12, 32'h0, 32'h4000_0000, 5'd3, "R7 sra pos");
                drive(5'd12, 32'h0, 32'h8000_0001, 5'd0, "R7 sra zero");
                // R9 rotates
                drive(5'd16, 32'h0, 32'h8000_0001, 5'd1, "R9 rol");
                drive(5'd17, 32'h0, 32'h1234_5678, 5'd8, "R9 ror");
                drive(5'd16, 32'h0, 32'hDEAD_BEEF, 5'd0, "R9 rol zero");
                // R8 variable amounts, garbage high bits and shamt
                drive(5'd13, 32'hFFFF_FFE3, 32'h0000_0001, 5'd7, "R8 sllv");
                drive(5'd14, 32'hABCD_EF04, 32'hF000_0000, 5'd1, "R8 srlv");
                drive(5'd15, 32'h8000_001F, 32'h8000_0000, 5'd2, "R8 srav");
                drive(5'd18, 32'h1234_5664, 32'h8000_000F, 5'd9, "R8 rolv");
                drive(5'd19, 32'hFFFF_FFE0, 32'h1357_9BDF, 5'd5, "R8 rorv zero amt");
                // R11 undefined
                drive(5'd20, 32'h7FFF_FFFF, 32'h0000_0001, 5'd3, "R11 undef 20");
                drive(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, "R11 undef 31");
                idle();
                // R10 idle after operations
                @(negedge clk);
                n_checks++;
                if (out_valid !== 1'b0 || wr_en !== 1'b0 || ovf_trap !== 1'b0 || result !== '0) begin
                    n_errors++;
                    $display("FAIL R10: idle v=%b res=%h ovf=%b we=%b expected all 0",
                             out_valid, result, ovf_trap, wr_en);
                end
                repeat (2) @(negedge clk);
                if (sb_q.size() != 0) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL R10: %0d results missing, expected 0", sb_q.size());
                end
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL R10: watchdog expired, expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule